// File: doc/BRIEF.md
# Serial Configuration Slave with Read Unlock

This block is the serial configuration port of a sensor analog front end. An external controller sends 16-bit frames over a three-wire serial bus: an active-low select, a serial clock and one shared data line. On the chip, that data line is split into an input, an output and an output enable. The block runs on a faster system clock. It oversamples the bus through synchronizers, finds the serial clock edges and decodes each frame. It keeps three byte-wide registers. The configuration register drives the amplifier stage enables, the filter-path select, the common-mode level select and two gain fields. The offset register drives an 8-bit DAC code. The third register, at address 0xF, is a write-only key register.

Writes are always accepted. Readback is refused until two key bytes, 0xFE and then 0xED, have been written to the key register in two consecutive complete frames. Once it is unlocked, the block drives the data line during the second half of each read frame and releases it at the end of the frame. It also releases it when the select line rises. Any other write to the key register locks readback again. The select line may stay low for good, in which case frames follow each other back to back.

The bus pins and configuration outputs are plain level signals. No streaming handshake applies.

Top module: `spi_cfg_slave`

## Requirements
- R1: After reset, the configuration outputs are all 0, `dac_code` is 0x80, `sdio_oe` is 0 and readback is locked.
- R2: A frame is 16 serial clock rising edges, sampled MSB first: an 8-bit command, then an 8-bit data byte. In the command, bit 7 = 1 means read and 0 means write, bits 6:4 are ignored, and bits 3:0 are the address. A write to address 0x0 sets `gain1_low` from bit 0, `gain2_code` from bits 2:1, `cm_high_sel` from bit 3, `ext_filter_sel` from bit 4, `stage2_en` from bit 5 and `stage1_en` from bit 6.
- R3: A write to address 0x1 sets `dac_code` to the data byte.
- R4: A register changes only once all 16 bits of a write have arrived. If the select line rises earlier, the frame is dropped and no register changes. The next frame starts counting from bit 0.
- R5: Writes to addresses other than 0x0, 0x1 and 0xF change no output.
- R6: While readback is locked, a read frame keeps `sdio_oe` low for the whole frame and changes nothing.
- R7: Readback unlocks only when a write of 0xFE to 0xF is followed, in the very next complete frame, by a write of 0xED to 0xF. Any other complete frame in between breaks the sequence.
- R8: During an unlocked read, `sdio_oe` rises after the 8th falling edge of the serial clock. The data byte then appears MSB first, with each bit changing on a falling edge. Address 0x0 reads back with bit 7 as 0. Address 0xF and unimplemented addresses read back as 0x00.
- R9: `sdio_oe` falls after the 16th rising edge of the serial clock, or when the select line rises, whichever comes first.
- R10: Once unlocked, any number of reads succeed. A write to 0xF of any value other than the second key byte of a valid sequence locks readback again.
- R11: With the select line held low, consecutive 16-bit frames are decoded back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_csn | input | 1 | Frame select, active low |
| spi_sck | input | 1 | Serial clock |
| sdio_in | input | 1 | Data line, input side |
| sdio_out | output | 1 | Data line, output side |
| sdio_oe | output | 1 | Data line output enable |
| stage1_en | output | 1 | First amplifier stage enable |
| stage2_en | output | 1 | Second amplifier stage enable |
| ext_filter_sel | output | 1 | Routes stage 1 to stage 2 through the external filter |
| cm_high_sel | output | 1 | Selects the high common-mode level |
| gain2_code | output | 2 | Second-stage gain code (0 to 3 for x4 to x32) |
| gain1_low | output | 1 | Selects the low first-stage gain |
| dac_code | output | 8 | Offset DAC code |

## Verification
The bench aims at the key sequence. A second key byte that arrives after an unrelated frame must not unlock, and a design that only remembered "first byte seen" would wrongly turn the data line around. Frames cut short after 12 and 15 bits test the commit point: a design that wrote early, or kept its bit count after the select line rose, would corrupt the offset code or misalign the next frame. Unlocked reads are sampled bit by bit on the rising edges. This catches a driver that starts one edge late, shifts on the wrong edge, leaks reserved bit 7, or keeps driving after the 16th edge or after an early rise of the select line. A back-to-back pair with the select line held low shows whether the frame counter wraps without needing that line.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int CMD_W  = 8;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] ADDR_CFG = 4'h0;
  localparam logic [ADDR_W-1:0] ADDR_DAC = 4'h1;
  localparam logic [ADDR_W-1:0] ADDR_KEY = 4'hF;

  localparam logic [DATA_W-1:0] CFG_RST    = 8'h00;
  localparam logic [DATA_W-1:0] DAC_RST    = 8'h80;
  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hFE;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'hED;

  // bit layout of the configuration byte, MSB first
  typedef struct packed {
    logic       rsv;
    logic       en_s1;
    logic       en_s2;
    logic       ext_path;
    logic       cm_high;
    logic [1:0] g2;
    logic       g1_low;
  } cfg_t;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= async_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame #(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 8,
  localparam int FRAME_BITS = CMD_W + DATA_W,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic              rd_open,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [CMD_W-1:0]  cmd_q,
  output logic              done,
  output logic [DATA_W-1:0] done_data,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [CNT_W-1:0]  bit_cnt
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] TURN_CNT = CNT_W'(CMD_W);

  logic              sck_q;
  logic              sck_rise, sck_fall;
  logic [FRAME_BITS-1:0] shreg;
  logic [DATA_W-1:0] rd_sh;

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign sdo      = rd_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q     <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
      cmd_q     <= '0;
      done      <= 1'b0;
      done_data <= '0;
      sdo_oe    <= 1'b0;
      rd_sh     <= '0;
    end else begin
      sck_q <= sck_s;
      done  <= 1'b0;
      if (csn_s) begin
        bit_cnt <= '0;
        sdo_oe  <= 1'b0;
      end else if (sck_rise) begin
        shreg <= {shreg[FRAME_BITS-2:0], sdi_s};
        if (bit_cnt == CMD_LAST)
          cmd_q <= {shreg[CMD_W-2:0], sdi_s};
        if (bit_cnt == LAST_BIT) begin
          bit_cnt   <= '0;
          done      <= 1'b1;
          done_data <= {shreg[DATA_W-2:0], sdi_s};
          sdo_oe    <= 1'b0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (sck_fall) begin
        if (bit_cnt == TURN_CNT && !sdo_oe) begin
          if (cmd_q[CMD_W-1] && rd_open) begin
            sdo_oe <= 1'b1;
            rd_sh  <= rd_byte;
          end
        end else if (sdo_oe) begin
          rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [CMD_W-1:0]  cmd_q,
  input  logic [DATA_W-1:0] done_data,
  output cfg_t              cfg_q,
  output logic [DATA_W-1:0] dac_q,
  output logic [DATA_W-1:0] rd_byte,
  output logic              rd_open,
  output logic              key_armed
);
  logic [ADDR_W-1:0] addr;
  logic              is_write;

  assign addr     = cmd_q[ADDR_W-1:0];
  assign is_write = ~cmd_q[CMD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= cfg_t'(CFG_RST);
      dac_q     <= DAC_RST;
      rd_open   <= 1'b0;
      key_armed <= 1'b0;
    end else if (done) begin
      key_armed <= 1'b0;
      if (is_write) begin
        unique case (addr)
          ADDR_CFG: begin
            cfg_q     <= cfg_t'(done_data);
            cfg_q.rsv <= 1'b0;
          end
          ADDR_DAC: dac_q <= done_data;
          ADDR_KEY: begin
            rd_open   <= key_armed && (done_data == KEY_SECOND);
            key_armed <= (done_data == KEY_FIRST);
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CFG: rd_byte = cfg_q;
      ADDR_DAC: rd_byte = dac_q;
      default:  rd_byte = '0;
    endcase
  end
endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_csn,
  input  logic       spi_sck,
  input  logic       sdio_in,
  output logic       sdio_out,
  output logic       sdio_oe,
  output logic       stage1_en,
  output logic       stage2_en,
  output logic       ext_filter_sel,
  output logic       cm_high_sel,
  output logic [1:0] gain2_code,
  output logic       gain1_low,
  output logic [7:0] dac_code
);
  localparam int CNT_W = $clog2(CMD_W + DATA_W + 1);

  logic [2:0]        pins_s;
  logic              csn_s, sck_s, sdi_s;
  logic [CMD_W-1:0]  cmd_q;
  logic              frm_done;
  logic [DATA_W-1:0] frm_data;
  logic [DATA_W-1:0] rd_byte;
  logic              rd_open, key_armed;
  logic [CNT_W-1:0]  bit_cnt;
  cfg_t              cfg_q;
  logic [DATA_W-1:0] dac_q;

  spi_cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({spi_csn, spi_sck, sdio_in}),
    .sync_out(pins_s)
  );
  assign {csn_s, sck_s, sdi_s} = pins_s;

  spi_cfg_frame #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .csn_s(csn_s), .sck_s(sck_s), .sdi_s(sdi_s),
    .rd_open(rd_open), .rd_byte(rd_byte),
    .cmd_q(cmd_q), .done(frm_done), .done_data(frm_data),
    .sdo(sdio_out), .sdo_oe(sdio_oe), .bit_cnt(bit_cnt)
  );

  spi_cfg_regs #(.CMD_W(CMD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .done(frm_done), .cmd_q(cmd_q), .done_data(frm_data),
    .cfg_q(cfg_q), .dac_q(dac_q), .rd_byte(rd_byte),
    .rd_open(rd_open), .key_armed(key_armed)
  );

  assign stage1_en      = cfg_q.en_s1;
  assign stage2_en      = cfg_q.en_s2;
  assign ext_filter_sel = cfg_q.ext_path;
  assign cm_high_sel    = cfg_q.cm_high;
  assign gain2_code     = cfg_q.g2;
  assign gain1_low      = cfg_q.g1_low;
  assign dac_code       = dac_q;
endmodule

// File: rtl/spi_cfg_slave_chk.sv
module spi_cfg_slave_chk #(
  parameter int CNT_W = 5,
  parameter int CMD_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             csn_s,
  input logic             sdio_oe,
  input logic             rd_open,
  input logic             key_armed,
  input logic             frm_done,
  input logic [7:0]       cfg_bits,
  input logic [7:0]       dac_q,
  input logic [CNT_W-1:0] bit_cnt
);
  // R6: the line is only driven while readback is open
  a_r6_oe_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> rd_open);

  // R9: a high select line releases the data line
  a_r9_release_on_csn: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !sdio_oe);

  // R4: registers move only on a completed frame
  a_r4_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_done |=> ($stable(cfg_bits) && $stable(dac_q)));

  // R7: unlocking needs the first key byte just before
  a_r7_unlock_after_first_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_open) |-> $past(key_armed));

  // R8: turnaround happens once the command byte is in
  a_r8_turn_after_command: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdio_oe) |-> (bit_cnt == CNT_W'(CMD_W)));
endmodule

bind spi_cfg_slave spi_cfg_slave_chk #(.CNT_W(CNT_W), .CMD_W(CMD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csn_s(csn_s), .sdio_oe(sdio_oe),
  .rd_open(rd_open), .key_armed(key_armed), .frm_done(frm_done),
  .cfg_bits(cfg_q), .dac_q(dac_q), .bit_cnt(bit_cnt)
);

// File: tb/spi_cfg_slave_tb.sv
`timescale 1ns/1ps
module spi_cfg_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_csn = 1'b1, spi_sck = 1'b0, sdio_in = 1'b0;
  logic sdio_out, sdio_oe;
  logic stage1_en, stage2_en, ext_filter_sel, cm_high_sel, gain1_low;
  logic [1:0] gain2_code;
  logic [7:0] dac_code;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  localparam int HALF = 80;

  always #5 clk = ~clk;

  spi_cfg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_csn(spi_csn), .spi_sck(spi_sck),
    .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
    .stage1_en(stage1_en), .stage2_en(stage2_en),
    .ext_filter_sel(ext_filter_sel), .cm_high_sel(cm_high_sel),
    .gain2_code(gain2_code), .gain1_low(gain1_low), .dac_code(dac_code)
  );

  function automatic logic [7:0] cfg_view();
    return {1'b0, stage1_en, stage2_en, ext_filter_sel, cm_high_sel, gain2_code, gain1_low};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one frame; nbits < 16 aborts by raising the select line
  task automatic xfer(input logic [7:0] cmd, input logic [7:0] dat, input int nbits,
                      input bit hold_cs, output logic [7:0] rb,
                      output bit oe_early, output bit oe_full, output bit oe_after);
    logic [15:0] word;
    word = {cmd, dat};
    rb = '0; oe_early = 0; oe_full = 1; oe_after = 0;
    spi_csn = 1'b0;
    #HALF;
    for (int i = 0; i < nbits; i++) begin
      sdio_in = word[15-i];
      #HALF;
      if (i >= 8) begin
        rb = {rb[6:0], sdio_out};
        if (!sdio_oe) oe_full = 0;
      end else if (sdio_oe) oe_early = 1;
      spi_sck = 1'b1;
      #HALF;
      spi_sck = 1'b0;
    end
    if (nbits < 16) oe_full = 0;
    #40;
    if (nbits < 16) begin
      spi_csn = 1'b1;
      #60;
      oe_after = sdio_oe;
      #100;
    end else begin
      oe_after = sdio_oe;
      if (!hold_cs) begin
        spi_csn = 1'b1;
        #160;
      end
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] rb; bit e, f, o;
    xfer({4'h0, a}, d, 16, 0, rb, e, f, o);
  endtask

  task automatic t_reset();
    chk(cfg_view() == 8'h00, "R1 cfg reset", cfg_view(), 0);
    chk(dac_code == 8'h80, "R1 dac reset", dac_code, 8'h80);
    chk(sdio_oe == 1'b0, "R1 oe reset", sdio_oe, 0);
  endtask

  task automatic t_cfg_write();
    wr(4'h0, 8'hFF);
    chk(cfg_view() == 8'h7F, "R2 cfg all ones", cfg_view(), 8'h7F);
    wr(4'h0, 8'h2A);
    chk(stage1_en == 0 && stage2_en == 1, "R2 enables", {stage1_en, stage2_en}, 1);
    chk(ext_filter_sel == 0 && cm_high_sel == 1, "R2 path and cm", {ext_filter_sel, cm_high_sel}, 1);
    chk(gain2_code == 2'b01 && gain1_low == 0, "R2 gains", {gain2_code, gain1_low}, 2);
    // reserved command bits 6:4 are ignored
    begin
      logic [7:0] rb; bit e, f, o;
      xfer(8'h70, 8'h41, 16, 0, rb, e, f, o);
      chk(cfg_view() == 8'h41, "R2 reserved cmd bits", cfg_view(), 8'h41);
    end
  endtask

  task automatic t_dac_write();
    wr(4'h1, 8'h3C);
    chk(dac_code == 8'h3C, "R3 dac write", dac_code, 8'h3C);
  endtask

  task automatic t_abort();
    logic [7:0] rb; bit e, f, o;
    xfer(8'h01, 8'h99, 12, 0, rb, e, f, o);
    chk(dac_code == 8'h3C, "R4 abort at 12", dac_code, 8'h3C);
    xfer(8'h01, 8'h99, 15, 0, rb, e, f, o);
    chk(dac_code == 8'h3C, "R4 abort at 15", dac_code, 8'h3C);
    wr(4'h1, 8'h55);
    chk(dac_code == 8'h55, "R4 fresh frame after abort", dac_code, 8'h55);
  endtask

  task automatic t_unimpl();
    wr(4'h5, 8'hFF);
    wr(4'h2, 8'h00);
    chk(cfg_view() == 8'h41 && dac_code == 8'h55, "R5 unimplemented write",
        {cfg_view(), dac_code}, 16'h4155);
  endtask

  task automatic t_locked_read();
    logic [7:0] rb; bit e, f, o;
    xfer(8'h81, 8'h00, 16, 0, rb, e, f, o);
    chk(!e && !f && !o, "R6 locked read", {e, f, o}, 0);
    chk(dac_code == 8'h55, "R6 read changes nothing", dac_code, 8'h55);
  endtask

  task automatic t_broken_seq();
    logic [7:0] rb; bit e, f, o;
    wr(4'hF, 8'hFE);
    wr(4'h1, 8'h77);
    wr(4'hF, 8'hED);
    xfer(8'h81, 8'h00, 16, 0, rb, e, f, o);
    chk(!e && !f, "R7 broken key sequence", {e, f}, 0);
  endtask

  task automatic t_unlocked_reads();
    logic [7:0] rb; bit e, f, o;
    wr(4'h0, 8'hFF);
    wr(4'hF, 8'hFE);
    wr(4'hF, 8'hED);
    xfer(8'h80, 8'h00, 16, 0, rb, e, f, o);
    chk(f && !e, "R8 drive window", {e, f}, 1);
    chk(rb == 8'h7F, "R8 cfg readback bit7 zero", rb, 8'h7F);
    chk(!o, "R9 release after 16th edge", o, 0);
    xfer(8'h81, 8'h00, 16, 0, rb, e, f, o);
    chk(f && rb == 8'h77, "R10 second read dac", rb, 8'h77);
    xfer(8'h8F, 8'h00, 16, 0, rb, e, f, o);
    chk(f && rb == 8'h00, "R8 key register reads zero", rb, 0);
    xfer(8'h85, 8'h00, 16, 0, rb, e, f, o);
    chk(f && rb == 8'h00, "R8 unimplemented reads zero", rb, 0);
    xfer(8'h81, 8'h00, 12, 0, rb, e, f, o);
    chk(!o, "R9 release on select rise", o, 0);
  endtask

  task automatic t_relock();
    logic [7:0] rb; bit e, f, o;
    wr(4'hF, 8'h12);
    xfer(8'h81, 8'h00, 16, 0, rb, e, f, o);
    chk(!e && !f, "R10 relock by stray key write", {e, f}, 0);
  endtask

  task automatic t_back_to_back();
    logic [7:0] rb; bit e, f, o;
    xfer(8'h01, 8'hA5, 16, 1, rb, e, f, o);
    xfer(8'h00, 8'h13, 16, 1, rb, e, f, o);
    xfer(8'h01, 8'h5A, 16, 0, rb, e, f, o);
    chk(dac_code == 8'h5A, "R11 back-to-back dac", dac_code, 8'h5A);
    chk(cfg_view() == 8'h13, "R11 back-to-back cfg", cfg_view(), 8'h13);
  endtask

  initial begin
    #2;
    repeat (5) #10;
    rst_n = 1'b1;
    #50;
    t_reset();
    t_cfg_write();
    t_dac_write();
    t_abort();
    t_unimpl();
    t_locked_read();
    t_broken_seq();
    t_unlocked_reads();
    t_relock();
    t_back_to_back();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule